// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the single atomic reservation that one processor keeps for a load-linked / store-conditional pair. A load-linked request opens a reservation. A later store-conditional asks whether that reservation is still intact. If it is, the store-conditional succeeds and its memory write is allowed. If it is not, the store-conditional fails and the write is suppressed. Either way, the reservation is consumed.

Two kinds of event break the reservation: an exception taken by the processor, and a coherence snoop (an invalidate or update) caused by another processor's store. A mode parameter chooses how snoops are judged. In whole-cache mode, any snoop cancels the reservation, so only the valid bit is stored. In line mode, the cache-line address of the loaded word is recorded, and only a snoop naming that same line cancels. In line mode, a store-conditional aimed at a different line also fails.

The store-conditional result is registered. It appears one clock after the request as a one-cycle response pulse that carries the success flag and the write gate.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset the reservation is empty, and `sc_resp`, `sc_ok` and `sc_wr_en` are 0.
- R2: A cycle with `ll_valid`=1 leaves a valid reservation behind. In line mode it also records the line of `ll_addr`.
- R3: A cycle with `sc_valid`=1 produces `sc_resp`=1 in the next cycle. `sc_ok` in that cycle equals the reservation bit as it stood before the request, and it is forced to 0 by any cancellation in the same cycle. In every other cycle `sc_resp` and `sc_ok` are 0.
- R4: `sc_wr_en` is 1 only together with `sc_ok`=1. A store-conditional without a reservation never opens the write gate.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails.
- R6: `exc_valid`=1 clears the reservation. A store-conditional in the same cycle as an exception fails.
- R7: In whole-cache mode (`MODE`=MATCH_ANY), any `snoop_valid` pulse clears the reservation, whatever its address.
- R8: In line mode (`MODE`=MATCH_LINE), a snoop clears the reservation only when its line equals the recorded line. A snoop to another line leaves the reservation untouched.
- R9: In line mode, a store-conditional whose line differs from the recorded line fails. In whole-cache mode the store-conditional address is not compared.
- R10: A load-linked in the same cycle as an exception, snoop or store-conditional wins: a fresh reservation is set. A store-conditional in that same cycle is judged on the old reservation.
- R11: The line of an address is the address with its low log2(`LINE_BYTES`) bits cleared. With 32-byte lines, 0x1000 and 0x101C share a line and 0x1020 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Byte address of the load-linked word |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Byte address of the store-conditional word |
| exc_valid | input | 1 | Exception taken by this processor |
| snoop_valid | input | 1 | Incoming invalidate or update snoop |
| snoop_addr | input | ADDR_W | Address carried by the snoop |
| sc_resp | output | 1 | Store-conditional response pulse, one cycle after the request |
| sc_ok | output | 1 | Store-conditional success flag |
| sc_wr_en | output | 1 | Write gate for the store-conditional's memory write |

## Verification
Two instances, one per mode, receive identical stimulus. Their responses are compared every clock against a behavioural model.

Directed sequences cover the main cases:
- a clean load-linked then store-conditional, which must succeed;
- a repeated store-conditional, which must fail;
- each cancelling event placed between or on top of the pair.

Some of these patterns separate the two modes: a snoop to a foreign line, a snoop to another word in the same line, and a store-conditional to a different line. A load-linked coinciding with a cancelling event checks the priority order. A long random phase uses addresses drawn from a few nearby lines, so same-line and cross-line collisions happen often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic {
        MATCH_ANY  = 1'b0,
        MATCH_LINE = 1'b1
    } match_mode_e;

    function automatic int offset_bits(input int line_bytes);
        return $clog2(line_bytes);
    endfunction

endpackage

// File: rtl/llsc_line_extract.sv
module llsc_line_extract #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] line_addr
);
    localparam int OFS_W = llsc_pkg::offset_bits(LINE_BYTES);
    localparam logic [ADDR_W-1:0] KEEP_MASK =
        ~((ADDR_W'(1) << OFS_W) - ADDR_W'(1));

    // R11: the line is the address with the in-line offset cleared
    assign line_addr = addr & KEEP_MASK;
endmodule

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
    parameter int                   ADDR_W = 32,
    parameter llsc_pkg::match_mode_e MODE  = llsc_pkg::MATCH_LINE
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] req_line,
    input  logic [ADDR_W-1:0] resv_line,
    output logic              hit
);
    generate
        if (MODE == llsc_pkg::MATCH_LINE) begin : g_line
            assign hit = req && (req_line == resv_line);
        end else begin : g_any
            assign hit = req;
        end
    endgenerate
endmodule

// File: rtl/llsc_resv_core.sv
module llsc_resv_core #(
    parameter int                   ADDR_W = 32,
    parameter llsc_pkg::match_mode_e MODE  = llsc_pkg::MATCH_LINE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_line,
    input  logic              sc_valid,
    input  logic              sc_line_ok,
    input  logic              exc_valid,
    input  logic              snoop_hit,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_line,
    output logic              sc_resp,
    output logic              sc_ok,
    output logic              sc_wr_en
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] line;
        logic              resp;
        logic              ok;
        logic              wr;
    } state_t;

    state_t st_d, st_q;
    logic   cancel_d;
    logic   pass_d;

    always_comb begin
        st_d     = st_q;
        cancel_d = exc_valid || snoop_hit;
        pass_d   = sc_valid && st_q.valid && sc_line_ok && !cancel_d;

        st_d.resp = sc_valid;
        st_d.ok   = pass_d;
        st_d.wr   = pass_d;

        if (ll_valid) begin
            st_d.valid = 1'b1;
            st_d.line  = (MODE == llsc_pkg::MATCH_LINE) ? ll_line : '0;
        end else if (sc_valid || cancel_d) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resv_valid = st_q.valid;
    assign resv_line  = st_q.line;
    assign sc_resp    = st_q.resp;
    assign sc_ok      = st_q.ok;
    assign sc_wr_en   = st_q.wr;

    // R2
    ll_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ll_valid |=> resv_valid);

    // R5
    sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !ll_valid) |=> !resv_valid);

    // R6
    exc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !ll_valid) |=> !resv_valid);

    // R6
    exc_blocks_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && sc_valid) |=> !sc_ok);

    // R3
    sc_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !resv_valid) |=> !sc_ok);

    // R4
    wr_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_wr_en |-> (sc_ok && sc_resp));
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
    parameter int                   ADDR_W     = 32,
    parameter int                   LINE_BYTES = 32,
    parameter llsc_pkg::match_mode_e MODE      = llsc_pkg::MATCH_LINE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              exc_valid,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              sc_resp,
    output logic              sc_ok,
    output logic              sc_wr_en
);
    logic [ADDR_W-1:0] ll_line;
    logic [ADDR_W-1:0] sc_line;
    logic [ADDR_W-1:0] snoop_line;
    logic [ADDR_W-1:0] resv_line;
    logic              resv_valid;
    logic              snoop_hit;
    logic              sc_line_ok;

    llsc_line_extract #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_ll_line (
        .addr(ll_addr), .line_addr(ll_line));
    llsc_line_extract #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_sc_line (
        .addr(sc_addr), .line_addr(sc_line));
    llsc_line_extract #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_sn_line (
        .addr(snoop_addr), .line_addr(snoop_line));

    llsc_line_cmp #(.ADDR_W(ADDR_W), .MODE(MODE)) u_snoop_cmp (
        .req(snoop_valid), .req_line(snoop_line),
        .resv_line(resv_line), .hit(snoop_hit));

    llsc_line_cmp #(.ADDR_W(ADDR_W), .MODE(MODE)) u_sc_cmp (
        .req(1'b1), .req_line(sc_line),
        .resv_line(resv_line), .hit(sc_line_ok));

    llsc_resv_core #(.ADDR_W(ADDR_W), .MODE(MODE)) u_core (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_line(ll_line),
        .sc_valid(sc_valid), .sc_line_ok(sc_line_ok),
        .exc_valid(exc_valid), .snoop_hit(snoop_hit),
        .resv_valid(resv_valid), .resv_line(resv_line),
        .sc_resp(sc_resp), .sc_ok(sc_ok), .sc_wr_en(sc_wr_en));

    // R7
    any_snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((MODE == llsc_pkg::MATCH_ANY) && snoop_valid && !ll_valid) |=> !resv_valid);

    // R8
    stray_snoop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && !snoop_hit && !ll_valid && !sc_valid && !exc_valid)
        |=> $stable(resv_valid));

    // R10
    ll_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_valid && (exc_valid || snoop_valid || sc_valid)) |=> resv_valid);
endmodule

// File: tb/llsc_resv_monitor_test.sv
module llsc_resv_monitor_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_valid = 1'b0, sc_valid = 1'b0, exc_valid = 1'b0, snoop_valid = 1'b0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snoop_addr = '0;
    logic          p_resp, p_ok, p_wr;
    logic          c_resp, c_ok, c_wr;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    string cur_tag  = "R1";

    always #10 clk = ~clk;

    llsc_resv_monitor #(.ADDR_W(AW), .LINE_BYTES(32), .MODE(llsc_pkg::MATCH_LINE)) uut (
        .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .exc_valid(exc_valid),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .sc_resp(p_resp), .sc_ok(p_ok), .sc_wr_en(p_wr));

    llsc_resv_monitor #(.ADDR_W(AW), .LINE_BYTES(32), .MODE(llsc_pkg::MATCH_ANY)) uut_c (
        .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .exc_valid(exc_valid),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .sc_resp(c_resp), .sc_ok(c_ok), .sc_wr_en(c_wr));

    // Behavioural reference: [0] = line mode, [1] = whole-cache mode
    bit          m_valid [2];
    int unsigned m_line  [2];
    bit          e_resp  [2];
    bit          e_ok    [2];

    function automatic int unsigned line_of(input logic [AW-1:0] a);
        return int'(a) / 32;   // R11: 32-byte lines
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_valid[k] <= 1'b0; m_line[k] <= 0; e_resp[k] <= 1'b0; e_ok[k] <= 1'b0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit kill;
                bit good;
                kill = exc_valid || (snoop_valid && (k == 1 || line_of(snoop_addr) == m_line[k]));
                good = sc_valid && m_valid[k] && !kill && (k == 1 || line_of(sc_addr) == m_line[k]);
                e_resp[k] <= sc_valid;
                e_ok[k]   <= good;
                if (ll_valid) begin
                    m_valid[k] <= 1'b1;
                    m_line[k]  <= line_of(ll_addr);
                end else if (sc_valid || kill) begin
                    m_valid[k] <= 1'b0;
                end
            end
        end
    end

    task automatic check_bit(input string what, input logic got, input bit exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %b expected %b", cur_tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        check_bit("line sc_resp", p_resp, e_resp[0]);
        check_bit("line sc_ok", p_ok, e_ok[0]);
        check_bit("line sc_wr_en", p_wr, e_ok[0]);
        check_bit("any sc_resp", c_resp, e_resp[1]);
        check_bit("any sc_ok", c_ok, e_ok[1]);
        check_bit("any sc_wr_en", c_wr, e_ok[1]);
    endtask

    // Drive one cycle of stimulus at a falling edge, then compare at the next falling edge
    task automatic cyc(input string tag, input bit ll, input logic [AW-1:0] la,
                       input bit sc, input logic [AW-1:0] sa, input bit ex,
                       input bit sn, input logic [AW-1:0] na);
        cur_tag = tag;
        ll_valid = ll; ll_addr = la; sc_valid = sc; sc_addr = sa;
        exc_valid = ex; snoop_valid = sn; snoop_addr = na;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, '0, 0, '0, 0, 0, '0);
    endtask

    initial begin
        logic [AW-1:0] pool [5];
        pool[0] = 32'h1000; pool[1] = 32'h1004; pool[2] = 32'h101C;
        pool[3] = 32'h1020; pool[4] = 32'h2000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R1";
        check_bit("line sc_resp", p_resp, 1'b0);
        check_bit("line sc_ok", p_ok, 1'b0);
        check_bit("any sc_wr_en", c_wr, 1'b0);
        // R1: reservation empty after reset, so an SC fails in both modes
        cyc("R1", 0, '0, 1, 32'h1000, 0, 0, '0);

        // R2 R3 R11: LL then SC to another word in the same line succeeds
        cyc("R2", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R3", 0, '0, 1, 32'h1004, 0, 0, '0);
        // R5: a second SC fails
        cyc("R5", 0, '0, 1, 32'h1004, 0, 0, '0);
        idle("R3");
        // R6: exception between LL and SC
        cyc("R6", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R6", 0, '0, 0, '0, 1, 0, '0);
        cyc("R6", 0, '0, 1, 32'h1000, 0, 0, '0);
        // R6: exception in the same cycle as SC
        cyc("R6", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R6", 0, '0, 1, 32'h1000, 1, 0, '0);
        // R7 R8: snoop to a foreign line
        cyc("R8", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R7", 0, '0, 0, '0, 0, 1, 32'h2000);
        cyc("R8", 0, '0, 1, 32'h1000, 0, 0, '0);
        // R8 R11: snoop to the last word of the reserved line
        cyc("R8", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R11", 0, '0, 0, '0, 0, 1, 32'h101C);
        cyc("R8", 0, '0, 1, 32'h1000, 0, 0, '0);
        // R11: 0x1020 is the next line
        cyc("R11", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R11", 0, '0, 0, '0, 0, 1, 32'h1020);
        cyc("R11", 0, '0, 1, 32'h101C, 0, 0, '0);
        // R9: SC to another line
        cyc("R9", 1, 32'h1000, 0, '0, 0, 0, '0);
        cyc("R9", 0, '0, 1, 32'h2000, 0, 0, '0);
        // R10: LL together with exception and snoop wins
        cyc("R10", 1, 32'h1000, 0, '0, 1, 1, 32'h1000);
        cyc("R10", 0, '0, 1, 32'h1000, 0, 0, '0);
        // R10: LL together with SC; SC judged on old (empty) reservation
        cyc("R10", 1, 32'h1000, 1, 32'h1000, 0, 0, '0);
        cyc("R10", 0, '0, 1, 32'h1000, 0, 0, '0);
        // R4: SC without reservation keeps write gate closed
        cyc("R4", 0, '0, 1, 32'h1000, 0, 0, '0);
        idle("R4");

        // Random phase: addresses from a few neighbouring lines
        for (int i = 0; i < 4000; i++) begin
            cyc("R2", ($urandom % 4) == 0, pool[$urandom % 5],
                ($urandom % 3) == 0, pool[$urandom % 5],
                ($urandom % 12) == 0,
                ($urandom % 5) == 0, pool[$urandom % 5]);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired in %s", cur_tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule